// File: doc/BRIEF.md
# Limit Input Qualifier with Ghost-Edge Detection

This block decides when a mechanical end-of-travel switch on a motorised curtain or blind has really been reached. The raw switch line is synchronised and normalised to an "active" level. The block then accepts it only when the motor is in its steady running phase. Edges that arrive while the motor is kicking off or reversing, or while the mechanism settles after a stop, are dropped. A candidate hit must survive two separate looks at the line, with a programmable gap between them, before the end-stop output is raised. The output then stays latched until the motion direction flips.

Alongside the decision, the block keeps per-event diagnostics: the number of switch edges seen during the event and a histogram of the spacing between successive edges. It also keeps a cumulative count of suspicious ("ghost") edges. An edge counts as a ghost when it is too narrow, when it is part of a tight burst, or when it appears while the motor is stopped and no new limit can be reached. A motor controller drives the phase code and the direction bit, reads the end-stop flag and logs the counters.

Top module: `limit_qual`

## Requirements
- R1: The active level of the raw input is selected by `act_high`: with `act_high`=1 a high input is active, with `act_high`=0 a low input is active. The raw line passes through a two-stage synchroniser, so an active level held from just before clock edge 1 raises `end_stop` after clock edge 3+`cfg_confirm`+`cfg_gap`.
- R2: Phase codes are 0 stopped, 1 kick (start or reversal), 2 running, 3 settling after a stop. Edges seen in phase 1 or 3 change nothing: no end-stop, no ghost count, no edge count, no histogram entry.
- R3: Every input edge seen in phase 0 adds one to `ghost_cnt`.
- R4: In phase 2, an active pulse lasting fewer than `cfg_min_width` cycles adds one to `ghost_cnt` and does not raise `end_stop`.
- R5: Confirmation has two stages. A rising edge in phase 2 must be followed by `cfg_confirm` consecutive active samples. After `cfg_gap` further cycles the level is sampled once more. `end_stop` rises only if that second sample is active; otherwise the block waits for a fresh rising edge.
- R6: An active pulse in phase 2 lasting at least `cfg_min_width` but fewer than `cfg_confirm` cycles is rejected without a ghost count.
- R7: Once raised, `end_stop` stays high whatever the level or phase, and it drops one clock after `dir` toggles.
- R8: In phase 2, a third edge arriving within `cfg_cluster_win` cycles of the edge that opened a cluster window adds one to `ghost_cnt`, once per window. An edge arriving later opens a new window.
- R9: `bounce_cnt` counts the phase-2 edges of the current event and saturates at 255. It is cleared when `dir` toggles and does not change while `end_stop` is high.
- R10: Each phase-2 edge after the first of an event adds one to histogram bin floor(log2(n)), capped at bin 7, where n is the cycle count since the previous counted edge. Bin i sits at bits [8i+7:8i] of `hist_bins`. Each bin saturates at 255. The bins are cleared when `dir` toggles and do not change while `end_stop` is high.
- R11: `ghost_cnt` is cumulative, is cleared only by reset, and saturates at 255.
- R12: After reset, `end_stop`, `ghost_cnt`, `bounce_cnt` and `hist_bins` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lim_raw | input | 1 | Raw, unsynchronised limit switch line |
| act_high | input | 1 | 1: input active high, 0: active low |
| phase | input | 2 | Motion phase: 0 stopped, 1 kick, 2 running, 3 settling |
| dir | input | 1 | Motion direction; a toggle starts a new event |
| cfg_min_width | input | 16 | Narrowest acceptable active pulse, in cycles |
| cfg_confirm | input | 16 | Active samples required by the first confirmation (at least 2) |
| cfg_gap | input | 16 | Cycles between first confirmation and second sample |
| cfg_cluster_win | input | 16 | Cluster window length, in cycles |
| end_stop | output | 1 | Qualified end-of-travel flag |
| ghost_cnt | output | 8 | Cumulative ghost-edge count |
| bounce_cnt | output | 8 | Edges counted in the current event |
| hist_bins | output | 64 | Eight 8-bit edge-interval histogram bins |

## Verification
A steady press separates the exact end-stop latency from an off-by-one in the synchroniser or in either confirmation stage. A press released during the gap shows that the second sample really gates the decision. Narrow, medium and long single pulses tell a ghost apart from a plain rejected bounce. Tight and loose three-edge bursts locate the cluster window boundary, and widely spaced pulses exercise the log2 binning and its top-bin cap. Edges under each phase code show the difference between blanking and stopped-phase ghost counting. Seeded random pulse widths against random confirm and gap settings cover the boundary where the release falls just before or just after the second sample. Long edge trains drive every counter into saturation.

// File: rtl/limit_qual_pkg.sv
package limit_qual_pkg;

   typedef enum logic [1:0] {
      PH_STOP   = 2'd0,
      PH_KICK   = 2'd1,
      PH_RUN    = 2'd2,
      PH_SETTLE = 2'd3
   } phase_e;

   typedef enum logic [1:0] {
      CQ_WAIT  = 2'd0,
      CQ_WIDE  = 2'd1,
      CQ_GAP   = 2'd2,
      CQ_LATCH = 2'd3
   } cq_state_e;

   // floor(log2(n)) clipped to the top bin; n = 0 or 1 maps to bin 0
   function automatic int interval_bin(input logic [31:0] n, input int nbin);
      int idx;
      idx = 0;
      for (int i = 1; i < 32; i++) begin
         if (n >= (32'd1 << i)) idx = i;
      end
      if (idx > nbin - 1) idx = nbin - 1;
      return idx;
   endfunction

endpackage

// File: rtl/lq_sync.sv
module lq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   input  logic act_high,
   output logic lvl,
   output logic rise,
   output logic fall
);
   logic              norm;
   logic [STAGES-1:0] chain;
   logic              lvl_d;

   // normalise before synchronising so a reset value of 0 means inactive
   assign norm = act_high ? raw : ~raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         lvl_d <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], norm};
         lvl_d <= chain[STAGES-1];
      end
   end

   assign lvl  = chain[STAGES-1];
   assign rise = lvl & ~lvl_d;
   assign fall = ~lvl & lvl_d;

endmodule

// File: rtl/lq_confirm.sv
module lq_confirm
   import limit_qual_pkg::*;
#(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lvl,
   input  logic          rise,
   input  logic          fall,
   input  logic          run,
   input  logic          rev,
   input  logic [TW-1:0] cfg_min_width,
   input  logic [TW-1:0] cfg_confirm,
   input  logic [TW-1:0] cfg_gap,
   output logic          end_stop,
   output logic          narrow
);
   cq_state_e     st;
   logic [TW-1:0] wcnt;
   logic [TW-1:0] gcnt;
   logic          first_ok;

   assign first_ok = ({1'b0, wcnt} + 1'b1) >= {1'b0, cfg_confirm};
   assign narrow   = (st == CQ_WIDE) && run && fall && (wcnt < cfg_min_width);
   assign end_stop = (st == CQ_LATCH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= CQ_WAIT;
         wcnt <= '0;
         gcnt <= '0;
      end else if (rev) begin
         st <= CQ_WAIT;
      end else begin
         unique case (st)
            CQ_WAIT: begin
               if (run && rise) begin
                  st   <= CQ_WIDE;
                  wcnt <= TW'(1);
               end
            end
            CQ_WIDE: begin
               if (!run || fall) begin
                  st <= CQ_WAIT;
               end else if (first_ok) begin
                  st   <= CQ_GAP;
                  gcnt <= '0;
               end else begin
                  wcnt <= wcnt + 1'b1;
               end
            end
            CQ_GAP: begin
               if (!run) begin
                  st <= CQ_WAIT;
               end else if (gcnt >= cfg_gap) begin
                  st <= lvl ? CQ_LATCH : CQ_WAIT;
               end else begin
                  gcnt <= gcnt + 1'b1;
               end
            end
            CQ_LATCH: st <= CQ_LATCH;
            default:  st <= CQ_WAIT;
         endcase
      end
   end

   // R5: the latch closes only on an active second sample taken while running
   a_r5_second_look: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(end_stop) |-> ($past(lvl) && $past(run)));

   // R7: the latch opens only on a direction change
   a_r7_release_on_rev: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(end_stop) |-> $past(rev));

   // R4: a narrow pulse never leads straight into the latch
   a_r4_narrow_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      narrow |=> !end_stop);

endmodule

// File: rtl/lq_ghost.sv
module lq_ghost #(
   parameter int TW = 16,
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_edge,
   input  logic          stop_edge,
   input  logic          narrow,
   input  logic [TW-1:0] cfg_cluster_win,
   output logic [CW-1:0] ghost_cnt
);
   localparam logic [CW-1:0] GMAX = '1;
   localparam logic [TW-1:0] TMAX = '1;

   logic [TW-1:0] ctim;
   logic [1:0]    ccnt;
   logic          open;
   logic          in_win;
   logic          cluster_hit;
   logic          bump;
   logic [CW-1:0] ghost_q;

   assign open        = (ccnt != 2'd0);
   assign in_win      = open && (ctim < cfg_cluster_win);
   assign cluster_hit = run_edge && in_win && (ccnt == 2'd2);
   assign bump        = narrow | stop_edge | cluster_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctim <= '0;
         ccnt <= 2'd0;
      end else if (run_edge) begin
         if (in_win) begin
            if (ccnt != 2'd3) ccnt <= ccnt + 2'd1;
            if (ctim != TMAX) ctim <= ctim + 1'b1;
         end else begin
            ccnt <= 2'd1;
            ctim <= '0;
         end
      end else if (open) begin
         if (ctim >= cfg_cluster_win) ccnt <= 2'd0;
         else                         ctim <= ctim + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    ghost_q <= '0;
      else if (bump && ghost_q != GMAX) ghost_q <= ghost_q + 1'b1;
   end

   assign ghost_cnt = ghost_q;

   // R11: the ghost count never falls and moves by at most one per cycle
   a_r11_ghost_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ghost_q == $past(ghost_q)) || (ghost_q == $past(ghost_q) + 1'b1));

   // R3: an edge while stopped is always counted until saturation
   a_r3_stop_counts: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_edge && ghost_q != GMAX) |=> (ghost_q != $past(ghost_q)));

endmodule

// File: rtl/lq_stats.sv
module lq_stats
   import limit_qual_pkg::*;
#(
   parameter int TW   = 16,
   parameter int CW   = 8,
   parameter int NBIN = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_edge,
   input  logic               clr,
   output logic [CW-1:0]      bounce_cnt,
   output logic [NBIN*CW-1:0] hist_bins
);
   localparam logic [CW-1:0] CMAX = '1;
   localparam logic [TW-1:0] SMAX = '1;

   logic [TW-1:0] since;
   logic          have_prev;
   logic [CW-1:0] bcnt;
   logic [TW:0]   interval;
   int            bidx;

   assign interval = {1'b0, since} + 1'b1;

   always_comb bidx = interval_bin(32'(interval), NBIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since     <= '0;
         have_prev <= 1'b0;
         bcnt      <= '0;
      end else if (clr) begin
         since     <= '0;
         have_prev <= 1'b0;
         bcnt      <= '0;
      end else if (run_edge) begin
         since     <= '0;
         have_prev <= 1'b1;
         if (bcnt != CMAX) bcnt <= bcnt + 1'b1;
      end else if (since != SMAX) begin
         since <= since + 1'b1;
      end
   end

   assign bounce_cnt = bcnt;

   for (genvar b = 0; b < NBIN; b++) begin : g_bin
      logic [CW-1:0] hq;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   hq <= '0;
         else if (clr) hq <= '0;
         else if (run_edge && have_prev && bidx == b && hq != CMAX) hq <= hq + 1'b1;
      end
      assign hist_bins[b*CW +: CW] = hq;
   end

   // R9: the edge count moves only on a counted edge or a clear
   a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_edge && !clr) |=> $stable(bcnt));

   // R10: the histogram moves only on a counted edge or a clear
   a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_edge && !clr) |=> $stable(hist_bins));

endmodule

// File: rtl/limit_qual.sv
module limit_qual
   import limit_qual_pkg::*;
#(
   parameter int TW          = 16,
   parameter int CW          = 8,
   parameter int NBIN        = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lim_raw,
   input  logic               act_high,
   input  logic [1:0]         phase,
   input  logic               dir,
   input  logic [TW-1:0]      cfg_min_width,
   input  logic [TW-1:0]      cfg_confirm,
   input  logic [TW-1:0]      cfg_gap,
   input  logic [TW-1:0]      cfg_cluster_win,
   output logic               end_stop,
   output logic [CW-1:0]      ghost_cnt,
   output logic [CW-1:0]      bounce_cnt,
   output logic [NBIN*CW-1:0] hist_bins
);
   if (TW < 4 || TW > 31) begin : g_bad_tw
      $error("limit_qual: TW must lie in 4..31");
   end
   if (CW < 2) begin : g_bad_cw
      $error("limit_qual: CW must be at least 2");
   end
   if (NBIN < 2 || NBIN > TW + 1) begin : g_bad_nbin
      $error("limit_qual: NBIN must lie in 2..TW+1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("limit_qual: SYNC_STAGES must be at least 2");
   end

   phase_e ph;
   logic   lvl, rise, fall, any_edge;
   logic   dir_d, rev;
   logic   is_run, is_blank;
   logic   run_edge, stop_edge, narrow;

   assign ph = phase_e'(phase);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dir_d <= 1'b0;
      else        dir_d <= dir;
   end

   assign rev       = dir ^ dir_d;
   assign any_edge  = rise | fall;
   assign is_run    = (ph == PH_RUN);
   assign is_blank  = (ph == PH_KICK) || (ph == PH_SETTLE);
   assign run_edge  = any_edge && is_run && !end_stop;
   assign stop_edge = any_edge && (ph == PH_STOP);

   lq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw      (lim_raw),
      .act_high (act_high),
      .lvl      (lvl),
      .rise     (rise),
      .fall     (fall)
   );

   lq_confirm #(.TW(TW)) u_confirm (
      .clk           (clk),
      .rst_n         (rst_n),
      .lvl           (lvl),
      .rise          (rise),
      .fall          (fall),
      .run           (is_run),
      .rev           (rev),
      .cfg_min_width (cfg_min_width),
      .cfg_confirm   (cfg_confirm),
      .cfg_gap       (cfg_gap),
      .end_stop      (end_stop),
      .narrow        (narrow)
   );

   lq_ghost #(.TW(TW), .CW(CW)) u_ghost (
      .clk             (clk),
      .rst_n           (rst_n),
      .run_edge        (run_edge),
      .stop_edge       (stop_edge),
      .narrow          (narrow),
      .cfg_cluster_win (cfg_cluster_win),
      .ghost_cnt       (ghost_cnt)
   );

   lq_stats #(.TW(TW), .CW(CW), .NBIN(NBIN)) u_stats (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_edge   (run_edge),
      .clr        (rev),
      .bounce_cnt (bounce_cnt),
      .hist_bins  (hist_bins)
   );

   // R2: a blanked phase leaves every diagnostic untouched
   a_r2_blank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (is_blank && !rev) |=> ($stable(ghost_cnt) && $stable(bounce_cnt) && $stable(hist_bins)));

endmodule

// File: tb/limit_qual_bench.sv
`timescale 1ns/1ps
module limit_qual_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lim_raw = 1'b0;
   logic        act_high = 1'b1;
   logic [1:0]  phase = 2'd2;
   logic        dir = 1'b0;
   logic [15:0] cfg_min_width = 16'd4;
   logic [15:0] cfg_confirm = 16'd10;
   logic [15:0] cfg_gap = 16'd6;
   logic [15:0] cfg_cluster_win = 16'd8;
   logic        end_stop;
   logic [7:0]  ghost_cnt;
   logic [7:0]  bounce_cnt;
   logic [63:0] hist_bins;

   int total = 0;
   int bad = 0;
   int exp_ghost = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   limit_qual u_limit_qual (
      .clk(clk), .rst_n(rst_n), .lim_raw(lim_raw), .act_high(act_high),
      .phase(phase), .dir(dir), .cfg_min_width(cfg_min_width),
      .cfg_confirm(cfg_confirm), .cfg_gap(cfg_gap),
      .cfg_cluster_win(cfg_cluster_win), .end_stop(end_stop),
      .ghost_cnt(ghost_cnt), .bounce_cnt(bounce_cnt), .hist_bins(hist_bins)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic press(input bit active);
      lim_raw = active ? act_high : ~act_high;
   endtask

   task automatic new_event();
      dir = ~dir;
      tick(2);
   endtask

   function automatic int exp_bin(input int n);
      int b;
      b = 0;
      while (b < 7 && n >= (2 << b)) b++;
      return b;
   endfunction

   function automatic logic [63:0] one_bin(input int b, input int v);
      logic [63:0] h;
      h = '0;
      h[b*8 +: 8] = 8'(v);
      return h;
   endfunction

   function automatic logic [7:0] bin_at(input int b);
      return hist_bins[b*8 +: 8];
   endfunction

   task automatic pulse_train(input int n, input int hi, input int lo);
      for (int i = 0; i < n; i++) begin
         press(1'b1); tick(hi);
         press(1'b0); tick(lo);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      tick(5);
      rst_n = 1'b1;
      tick(1);
      // R12 reset state
      check("R12 end_stop", 64'(end_stop), 0);
      check("R12 ghost", 64'(ghost_cnt), 0);
      check("R12 bounce", 64'(bounce_cnt), 0);
      check("R12 hist", hist_bins, 0);

      // R5 exact latency of a steady press
      press(1'b1);
      tick(2 + 10 + 6);
      check("R5 not yet latched", 64'(end_stop), 0);
      tick(1);
      check("R5 latched", 64'(end_stop), 1);
      check("R9 one edge", 64'(bounce_cnt), 1);
      press(1'b0);
      tick(20);
      check("R7 held after release", 64'(end_stop), 1);
      check("R9 frozen while latched", 64'(bounce_cnt), 1);
      phase = 2'd3;
      tick(5);
      check("R7 held in settle", 64'(end_stop), 1);
      dir = ~dir;
      tick(1);
      check("R7 released by dir", 64'(end_stop), 0);
      check("R9 cleared by dir", 64'(bounce_cnt), 0);
      phase = 2'd2;
      tick(20);

      // R5 release during the gap: second sample inactive
      press(1'b1); tick(12); press(1'b0); tick(30);
      check("R5 second sample low", 64'(end_stop), 0);
      check("R6 no ghost", 64'(ghost_cnt), 0);
      check("R9 two edges", 64'(bounce_cnt), 2);
      check("R10 interval 12", 64'(bin_at(3)), 1);
      press(1'b1); tick(25); press(1'b0); tick(30);
      check("R5 fresh edge qualifies", 64'(end_stop), 1);
      check("R9 three edges", 64'(bounce_cnt), 3);
      new_event();

      // R4 narrow pulse
      press(1'b1); tick(2); press(1'b0); tick(30);
      exp_ghost++;
      check("R4 ghost", 64'(ghost_cnt), 64'(exp_ghost));
      check("R4 no latch", 64'(end_stop), 0);
      check("R10 interval 2", 64'(bin_at(1)), 1);
      // R6 medium pulse
      press(1'b1); tick(6); press(1'b0); tick(30);
      check("R6 no ghost", 64'(ghost_cnt), 64'(exp_ghost));
      check("R6 no latch", 64'(end_stop), 0);
      check("R10 interval 6", 64'(bin_at(2)), 1);
      check("R10 interval 30", 64'(bin_at(4)), 1);
      new_event();

      // R2 blanking in kick and settle
      phase = 2'd1; tick(1);
      press(1'b1); tick(40);
      check("R2 kick no latch", 64'(end_stop), 0);
      press(1'b0); tick(10);
      phase = 2'd3; tick(1);
      press(1'b1); tick(40); press(1'b0); tick(10);
      check("R2 no latch", 64'(end_stop), 0);
      check("R2 ghost unchanged", 64'(ghost_cnt), 64'(exp_ghost));
      check("R2 bounce zero", 64'(bounce_cnt), 0);
      check("R2 hist zero", hist_bins, 0);

      // R3 edges while stopped
      phase = 2'd0; tick(1);
      press(1'b1); tick(5); press(1'b0); tick(10);
      exp_ghost += 2;
      check("R3 ghost", 64'(ghost_cnt), 64'(exp_ghost));
      check("R3 bounce zero", 64'(bounce_cnt), 0);
      phase = 2'd2; tick(2);

      // R8 tight cluster, then loose edges
      cfg_min_width = 16'd1;
      pulse_train(2, 2, 2);
      tick(26);
      exp_ghost++;
      check("R8 cluster ghost", 64'(ghost_cnt), 64'(exp_ghost));
      check("R9 four edges", 64'(bounce_cnt), 4);
      check("R10 three short gaps", 64'(bin_at(1)), 3);
      pulse_train(2, 5, 5);
      tick(25);
      check("R8 loose no ghost", 64'(ghost_cnt), 64'(exp_ghost));
      check("R10 three gaps of 5", 64'(bin_at(2)), 3);
      cfg_min_width = 16'd4;
      new_event();

      // R10 bin 0 and top-bin cap
      cfg_confirm = 16'd1000;
      press(1'b1); tick(1); press(1'b0); tick(200);
      press(1'b1); tick(1); press(1'b0); tick(20);
      exp_ghost += 2;
      check("R10 bin0", 64'(bin_at(0)), 2);
      check("R10 capped bin7", 64'(bin_at(7)), 1);
      check("R4 two narrow", 64'(ghost_cnt), 64'(exp_ghost));
      cfg_confirm = 16'd10;
      new_event();

      // R1 active-low input
      act_high = 1'b0; lim_raw = 1'b1;
      tick(10);
      check("R1 no spurious edge", 64'(bounce_cnt), 0);
      lim_raw = 1'b0;
      tick(18);
      check("R1 active-low early", 64'(end_stop), 0);
      tick(1);
      check("R1 active-low latched", 64'(end_stop), 1);
      lim_raw = 1'b1;
      tick(10);
      new_event();
      check("R1 released", 64'(end_stop), 0);
      act_high = 1'b1; lim_raw = 1'b0;
      tick(10);

      // R5 R6 R4 R9 R10 random widths against random settings
      for (int t = 0; t < 30; t++) begin
         int c, g, w;
         bit es;
         c = 4 + int'($urandom % 17);
         g = int'($urandom % 16);
         w = 1 + int'($urandom % 40);
         cfg_confirm = 16'(c);
         cfg_gap = 16'(g);
         new_event();
         press(1'b1); tick(w); press(1'b0); tick(60);
         es = (w >= c + g + 1);
         if (w < 4) exp_ghost++;
         check("R5 random latch", 64'(end_stop), 64'(es));
         check("R4 random ghost", 64'(ghost_cnt), 64'(exp_ghost));
         check("R9 random edges", 64'(bounce_cnt), es ? 64'd1 : 64'd2);
         check("R10 random hist", hist_bins, es ? 64'd0 : one_bin(exp_bin(w), 1));
      end
      cfg_confirm = 16'd10;
      cfg_gap = 16'd6;
      new_event();

      // R11 ghost saturation
      phase = 2'd0; tick(1);
      pulse_train(140, 2, 2);
      tick(5);
      check("R11 ghost saturates", 64'(ghost_cnt), 255);

      // R9 R10 saturation
      phase = 2'd2; tick(1);
      new_event();
      cfg_min_width = 16'd1;
      cfg_confirm = 16'd1000;
      pulse_train(150, 2, 2);
      tick(5);
      check("R9 bounce saturates", 64'(bounce_cnt), 255);
      check("R10 bin saturates", 64'(bin_at(1)), 255);
      check("R5 no latch on bursts", 64'(end_stop), 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule